// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital control core of an integrating (dual-slope) analog-to-digital converter. It runs from the oscillator clock, divides it down to a count rate, and steps the analog switch network through three phases: zeroing the offsets, integrating the unknown input for a fixed time, and integrating a reference of opposite sign until the integrator returns to its starting level. The analog integrator, buffer, switches, reference and display are outside the block. The only analog feedback it receives is the comparator that watches the integrator output.

Each measurement cycle has a fixed length. The reference phase is timed in decimal (BCD) counts, and that count is the conversion result. Any part of the reference window that the conversion does not use is added to the following zeroing phase, so the zeroing time changes with the input while the cycle length stays the same. The sign of the input is taken from the comparator when the fixed integration ends. That sign chooses which reference switch is closed. The result, the sign and an overrange flag are loaded into output registers once per cycle, at the moment the reference phase ends.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst_ni` is low, and immediately when it falls, `phase_o` is 4'b0001 (zeroing), `reading_o` is 0, `polarity_o` is 0 and `over_o` is 0.
- R2: Exactly one bit of `phase_o` is high at all times. Bit 0 is zeroing, bit 1 is input integration, bit 2 is the reference phase for a positive input, and bit 3 is the reference phase for a negative input.
- R3: The phases always follow the order zeroing, then input integration, then one reference phase, then zeroing again.
- R4: One count is 4 oscillator clocks. Input integration lasts exactly 1000 counts (4000 clocks).
- R5: From the start of one input integration to the start of the next is always 4000 counts (16000 clocks). The first zeroing phase after reset release lasts 1000 counts (4000 clocks).
- R6: The comparator level, after a two-flop synchronizer, is sampled on the last count of input integration. If it is high, bit 2 of `phase_o` follows and `polarity_o` is later loaded with 0. If it is low, bit 3 follows and `polarity_o` is later loaded with 1.
- R7: The reference phase ends on the first count at which the synchronized comparator differs from the sampled level. `reading_o` is then loaded with the number of whole counts that came before that count, in BCD with the thousands digit in bits 15:12 and the units digit in bits 3:0. The phase lasts that number plus one counts, and the range of results is 0 to 1999.
- R8: If no crossing is seen in 2000 counts, the reference phase ends after exactly 2000 counts (8000 clocks), `over_o` is loaded with 1 and `reading_o` with BCD 1999. The next conversion that ends by crossing clears `over_o`.
- R9: `reading_o`, `polarity_o` and `over_o` change only on the clock edge where a reference phase ends. At every other time they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_i | input | 1 | Integrator comparator output, asynchronous |
| phase_o | output | 4 | One-hot switch control: zero, input, reference for positive input, reference for negative input |
| polarity_o | output | 1 | Latched sign, 1 for a negative input |
| reading_o | output | 16 | Latched BCD result, four digits |
| over_o | output | 1 | Latched overrange flag |

## Verification
If the cycle-position counter is wrong, the fault appears at the ports within one cycle as a wrong input-integration length or a wrong spacing between integration starts, measured in clocks. If the result counter or the crossing detection is wrong, the fault appears in the reference-phase length and in the value loaded at the end of that same phase. If the sign capture is wrong, the wrong reference bit is selected one clock after input integration ends. Stale or early updates of the output registers show up as changes in the middle of a reference phase, or as a changed result seen at the start of the next integration.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_ZERO = 2'd0,
    PH_INT  = 2'd1,
    PH_RPOS = 2'd2,
    PH_RNEG = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 4;

  // Binary to packed BCD (up to eight digits), for constants only.
  function automatic logic [31:0] bin2bcd(input int value);
    logic [31:0] res;
    int          rem;
    res = '0;
    rem = value;
    for (int d = 0; d < 8; d++) begin
      res[4*d +: 4] = 4'(rem % 10);
      rem           = rem / 10;
    end
    return res;
  endfunction

endpackage

// File: rtl/dsadc_tick.sv
module dsadc_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = chain_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_bcd.sv
module dsadc_bcd #(
  parameter int DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   val_o
);
  logic [DIGITS:0] carry;

  assign carry[0] = inc_i;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      logic [3:0] dig_q, dig_d;
      logic       at_nine;

      assign at_nine      = (dig_q == 4'd9);
      assign carry[g+1]   = carry[g] & at_nine;
      assign val_o[4*g +: 4] = dig_q;

      always_comb begin
        dig_d = dig_q;
        if (clr_i)         dig_d = 4'd0;
        else if (carry[g]) dig_d = at_nine ? 4'd0 : dig_q + 4'd1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dig_q <= 4'd0;
        else         dig_q <= dig_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int SI_CNT  = 1000,
  parameter int RI_MAX  = 2000,
  parameter int CYC_CNT = 4000,
  parameter int DIGITS  = 4,
  parameter int SYNC    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_i,
  output logic [3:0]           phase_o,
  output logic                 polarity_o,
  output logic [4*DIGITS-1:0]  reading_o,
  output logic                 over_o
);
  localparam int BCD_W  = 4 * DIGITS;
  localparam int POS_W  = $clog2(CYC_CNT);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CYC_CNT - 1);
  localparam logic [POS_W-1:0] INT_LAST  = POS_W'(SI_CNT - 1);
  localparam logic [POS_W-1:0] ZERO_INIT = POS_W'(SI_CNT + RI_MAX);
  localparam logic [31:0]      TERM_FULL = bin2bcd(RI_MAX - 1);
  localparam logic [BCD_W-1:0] REF_TERM  = TERM_FULL[BCD_W-1:0];

  // Count enable and synchronized comparator
  logic tick, cmp_s;

  dsadc_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dsadc_sync #(.STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  // Result counter
  logic             bcd_clr, bcd_inc;
  logic [BCD_W-1:0] bcd_val;

  dsadc_bcd #(.DIGITS(DIGITS)) u_bcd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bcd_clr),
    .inc_i  (bcd_inc),
    .val_o  (bcd_val)
  );

  // Sequencer state
  phase_e           ph_q, ph_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             lvl_q, lvl_d;
  logic [3:0]       onehot_q, onehot_d;
  logic             load_out, load_over;

  // Output registers
  logic [BCD_W-1:0] rd_q;
  logic             pol_q, ovr_q;

  always_comb begin
    ph_d      = ph_q;
    pos_d     = pos_q;
    lvl_d     = lvl_q;
    bcd_clr   = 1'b0;
    bcd_inc   = 1'b0;
    load_out  = 1'b0;
    load_over = 1'b0;
    if (tick) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      unique case (ph_q)
        PH_ZERO: begin
          if (pos_q == POS_LAST) ph_d = PH_INT;
        end
        PH_INT: begin
          if (pos_q == INT_LAST) begin
            lvl_d   = cmp_s;
            ph_d    = cmp_s ? PH_RPOS : PH_RNEG;
            bcd_clr = 1'b1;
          end
        end
        default: begin
          if (cmp_s != lvl_q) begin
            load_out = 1'b1;
            ph_d     = PH_ZERO;
          end else if (bcd_val == REF_TERM) begin
            load_out  = 1'b1;
            load_over = 1'b1;
            ph_d      = PH_ZERO;
          end else begin
            bcd_inc = 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    onehot_d = 4'b0000;
    onehot_d[ph_d] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_ZERO;
      pos_q    <= ZERO_INIT;
      lvl_q    <= 1'b0;
      onehot_q <= 4'b0001;
    end else begin
      ph_q     <= ph_d;
      pos_q    <= pos_d;
      lvl_q    <= lvl_d;
      onehot_q <= onehot_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      pol_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (load_out) begin
      rd_q  <= bcd_val;
      pol_q <= ~lvl_q;
      ovr_q <= load_over;
    end
  end

  assign phase_o    = onehot_q;
  assign reading_o  = rd_q;
  assign polarity_o = pol_q;
  assign over_o     = ovr_q;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int DIV     = 4,
  parameter int SI_CNT  = 1000,
  parameter int RI_MAX  = 2000,
  parameter int CYC_CNT = 4000,
  parameter int DIGITS  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          phase_o,
  input logic                polarity_o,
  input logic [4*DIGITS-1:0] reading_o,
  input logic                over_o
);
  localparam int LW = $clog2(2 * CYC_CNT * DIV + 2);
  localparam logic [LW-1:0] INT_CLKS = LW'(SI_CNT * DIV);
  localparam logic [LW-1:0] CYC_CLKS = LW'(CYC_CNT * DIV);
  localparam logic [LW-1:0] REF_CLKS = LW'(RI_MAX * DIV);

  logic          ref_any;
  logic [LW-1:0] int_len, ref_len, cyc_len;
  logic          int_prev, armed;

  assign ref_any = phase_o[2] | phase_o[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_len  <= '0;
      ref_len  <= '0;
      cyc_len  <= '0;
      int_prev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      int_len  <= phase_o[1] ? int_len + 1'b1 : '0;
      ref_len  <= ref_any ? ref_len + 1'b1 : '0;
      int_prev <= phase_o[1];
      if (phase_o[1] && !int_prev) begin
        cyc_len <= LW'(1);
        armed   <= 1'b1;
      end else if (cyc_len != '1) begin
        cyc_len <= cyc_len + 1'b1;
      end
    end
  end

  // R2
  phase_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);

  // R3
  int_after_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o[1]) |-> $past(phase_o[0]));

  // R3
  ref_after_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_any) |-> $past(phase_o[1]));

  // R3
  zero_after_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o[0]) |-> $past(ref_any));

  // R4
  int_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phase_o[1]) |-> int_len == INT_CLKS);

  // R5
  cyc_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(phase_o[1]) && armed) |-> cyc_len == CYC_CLKS);

  // R8
  ref_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_len <= REF_CLKS);

  // R6
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_any) |-> polarity_o == $past(phase_o[3]));

  // R9
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ref_any) |-> ($stable(reading_o) && $stable(polarity_o) && $stable(over_o)));
endmodule

bind dsadc_seq dsadc_seq_chk #(
  .DIV     (DIV),
  .SI_CNT  (SI_CNT),
  .RI_MAX  (RI_MAX),
  .CYC_CNT (CYC_CNT),
  .DIGITS  (DIGITS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_o    (phase_o),
  .polarity_o (polarity_o),
  .reading_o  (reading_o),
  .over_o     (over_o)
);

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
  logic        clk, rst_n, cmp;
  logic [3:0]  phase;
  logic        pol, ovr;
  logic [15:0] rd;

  int clk_n  = 0;
  int n_tot  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Stimulus table: crossing count (-1 means never crosses) and comparator level
  localparam int NV = 6;
  localparam int VD [NV] = '{0, 1234, 567, 1999, -1, 42};
  localparam bit VL [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  dsadc_seq u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmp_i      (cmp),
    .phase_o    (phase),
    .polarity_o (pol),
    .reading_o  (rd),
    .over_o     (ovr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) clk_n <= clk_n + 1;

  function automatic logic [15:0] tb_bcd(input int v);
    logic [15:0] r;
    int          x;
    x = v;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    int          prev_si;
    int          t_si, t_ri, t_az, t0, exp_len;
    logic [15:0] exp_rd;
    bit          exp_pol, exp_ovr;

    clk   = 1'b0;
    rst_n = 1'b0;
    cmp   = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 4'b0001, "R1", "reset phase", phase, 4'b0001);
    chk(rd == 16'h0, "R1", "reset reading", rd, 0);
    chk(pol == 1'b0 && ovr == 1'b0, "R1", "reset sign/over", {pol, ovr}, 0);
    rst_n = 1'b1;

    prev_si = -1;
    exp_rd  = '0;
    exp_pol = 1'b0;
    exp_ovr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      while (!phase[0]) @(negedge clk);
      cmp = VL[i];
      while (!phase[1]) @(negedge clk);
      t_si = clk_n;
      if (prev_si >= 0)
        chk(t_si - prev_si == 16000, "R5", "cycle length", t_si - prev_si, 16000);
      chk(rd == exp_rd && ovr == exp_ovr, "R9", "held result at integration start", rd, exp_rd);
      prev_si = t_si;

      while (!(phase[2] | phase[3])) @(negedge clk);
      t_ri = clk_n;
      chk(t_ri - t_si == 4000, "R4", "integration length", t_ri - t_si, 4000);
      chk(phase == (VL[i] ? 4'b0100 : 4'b1000), "R6", "reference select", phase,
          VL[i] ? 4'b0100 : 4'b1000);

      if (VD[i] >= 0) begin
        repeat (4 * VD[i] + 1) @(negedge clk);
        chk(rd == exp_rd && pol == exp_pol, "R9", "result held during reference", rd, exp_rd);
        cmp = ~VL[i];
        exp_rd  = tb_bcd(VD[i]);
        exp_len = 4 * (VD[i] + 1);
        exp_ovr = 1'b0;
      end else begin
        exp_rd  = tb_bcd(1999);
        exp_len = 8000;
        exp_ovr = 1'b1;
      end
      exp_pol = ~VL[i];

      while (!phase[0]) @(negedge clk);
      t_az = clk_n;
      if (exp_ovr) begin
        chk(t_az - t_ri == exp_len, "R8", "overrange reference length", t_az - t_ri, exp_len);
        chk(ovr == 1'b1, "R8", "over flag", ovr, 1);
        chk(rd == exp_rd, "R8", "overrange reading", rd, exp_rd);
      end else begin
        chk(t_az - t_ri == exp_len, "R7", "reference length", t_az - t_ri, exp_len);
        chk(rd == exp_rd, "R7", "reading", rd, exp_rd);
        chk(ovr == 1'b0, "R8", "over flag clear", ovr, 0);
      end
      chk(pol == exp_pol, "R6", "polarity", pol, exp_pol);
    end

    // Directed: reset in the middle of a reference phase
    while (!phase[1]) @(negedge clk);
    while (!(phase[2] | phase[3])) @(negedge clk);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(phase == 4'b0001, "R1", "async reset phase", phase, 4'b0001);
    chk(rd == 16'h0 && pol == 1'b0 && ovr == 1'b0, "R1", "async reset outputs", rd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    t0 = clk_n;
    while (!phase[1]) @(negedge clk);
    chk(clk_n - t0 == 4000, "R5", "first zeroing length", clk_n - t0, 4000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule